// File: doc/BRIEF.md
# Per-Thread Squash Request Arbiter

This block sits in the retirement stage of a multithreaded out-of-order core. Every cycle, for each hardware thread, it looks at up to four reasons to throw away in-flight work. It takes the highest-priority reason and works out the sequence number to roll back to. It then registers a squash broadcast for the earlier pipeline stages, and the broadcast carries the redirect PC and branch outcome.

The four reasons are a trap that has become due, a write to architectural state from outside the pipeline, a deferred squash left by an instruction that asked for one after it retired, and a squash from the execute stage. An execute-stage squash is caused by a branch mispredict or a memory-order violation. The arbiter also holds each thread's status and the youngest sequence number inserted for that thread. While a thread is squashing, retirement for that thread is blocked until the buffer reports that its squash walk is finished. Threads are fully independent of each other.

Top module: `squash_arbiter`

## Requirements
- R1: Per thread, the winning cause follows a fixed priority, from highest to lowest: trap, external write, deferred squash-after, execute. `cause_o` encodes the winner: 0 none, 1 trap, 2 external write, 3 squash-after, 4 execute.
- R2: A trap request and an external-write request are never both high for one thread. An external-write request never arrives while that thread's status is trap-wait.
- R3: An execute squash is taken only if the thread is not in trap-wait and its sequence number is not larger than the thread's youngest recorded sequence number. Otherwise it has no effect.
- R4: The boundary of a taken execute squash is the given sequence number, or that number minus one when `exe_incl_i` is set. The thread's youngest sequence number becomes this boundary.
- R5: For a trap, external-write or squash-after squash, the boundary is `last_commit_seq_i` when the buffer is empty, and `rob_head_seq_i` minus one otherwise. The youngest sequence number is reset to `last_commit_seq_i`.
- R6: `taken_o` copies `exe_taken_i` for an execute squash, but is forced to 1 when the squash is a mispredict of an unconditional control instruction. `mispred_o` reports a mispredict. For whole-thread squashes both are 0.
- R7: A squash taken from inputs sampled at clock edge k sets `sq_o`, `robsq_o`, `done_seq_o`, `cause_o` and `pc_o` right after edge k. At the same point `status_o` becomes rob-squashing (2). `pc_o` is `exe_pc_i` for an execute squash and `cur_pc_i` otherwise.
- R8: While status is rob-squashing, `commit_ok_o` is 0 and `robsq_o` stays asserted. The status returns to running (0) only at the edge where `rob_sq_done_i` is high.
- R9: An insert (`ins_valid_i`) updates the youngest sequence number only when the thread is neither rob-squashing nor in trap-wait.
- R10: `trap_wait_set_i` moves a running thread to trap-wait (1). `sqafter_set_i` moves it to squash-after-wait (3), which raises a squash-after squash on the following cycle. Trap-wait is left only through a trap squash.
- R11: Requests for one thread never change another thread's outputs or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| trap_sq_i | input | NT | Trap squash due, per thread |
| xwrite_sq_i | input | NT | External state-write squash, per thread |
| sqafter_set_i | input | NT | Retired instruction requests a deferred squash |
| trap_wait_set_i | input | NT | Thread enters trap-wait |
| exe_sq_i | input | NT | Execute-stage squash request |
| exe_seq_i | input | NT*SW | Execute squash sequence number |
| exe_incl_i | input | NT | Squash includes the named instruction |
| exe_mispred_i | input | NT | Execute squash is a branch mispredict |
| exe_uncond_i | input | NT | Mispredicted branch is unconditional |
| exe_taken_i | input | NT | Branch outcome from execute |
| exe_pc_i | input | NT*PW | Redirect PC from execute |
| cur_pc_i | input | NT*PW | Thread commit PC |
| rob_empty_i | input | NT | Buffer empty for thread |
| rob_head_seq_i | input | NT*SW | Sequence number at buffer head |
| last_commit_seq_i | input | NT*SW | Last retired sequence number |
| ins_valid_i | input | NT | Instruction inserted this cycle |
| ins_seq_i | input | NT*SW | Sequence number of inserted instruction |
| rob_sq_done_i | input | NT | Buffer squash walk complete |
| sq_o | output | NT | Squash broadcast |
| robsq_o | output | NT | Buffer-squashing broadcast |
| done_seq_o | output | NT*SW | Squash boundary sequence number |
| cause_o | output | NT*3 | Winning cause code |
| taken_o | output | NT | Branch-taken to predictor |
| mispred_o | output | NT | Squash was a mispredict |
| pc_o | output | NT*PW | Redirect PC |
| status_o | output | NT*2 | Thread status (0 run, 1 trap-wait, 2 rob-squashing, 3 squash-after-wait) |
| commit_ok_o | output | NT | Thread may retire this cycle |

## Verification
Some properties are checked by assertions on every cycle. These are that the grant is one-hot, that a trap request always wins, and that the request inputs keep their exclusivity rules. They also cover that a broadcast squash always goes with the rob-squashing status, that the status holds until the done signal, and that an execute squash leaves the youngest register equal to the boundary. Only the directed scenarios show that the numbers are right. That covers the boundary arithmetic for empty and non-empty buffers, and the rejection of a squash younger than the last insert. It also covers inserts being ignored during a squash, the forced taken flag, and that a thread's squash leaves the other thread untouched.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;
  localparam int NUM_CAUSE = 4;

  typedef enum logic [1:0] {
    TS_RUN        = 2'd0,
    TS_TRAP_WAIT  = 2'd1,
    TS_ROB_SQ     = 2'd2,
    TS_AFTER_WAIT = 2'd3
  } tstat_e;

  typedef enum logic [2:0] {
    SC_NONE   = 3'd0,
    SC_TRAP   = 3'd1,
    SC_XWRITE = 3'd2,
    SC_AFTER  = 3'd3,
    SC_EXEC   = 3'd4
  } cause_e;
endpackage

// File: rtl/sqarb_prio.sv
module sqarb_prio
  import sqarb_pkg::*;
(
  input  logic [NUM_CAUSE-1:0] req,
  output logic [NUM_CAUSE-1:0] grant,
  output cause_e               cause
);
  // Index 0 is the highest priority; scanning downward lets the lowest index win.
  always_comb begin
    grant = '0;
    cause = SC_NONE;
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        cause    = cause_e'(3'(i + 1));
      end
    end
  end
endmodule

// File: rtl/sqarb_bound.sv
module sqarb_bound #(
  parameter int SEQ_W = 16
) (
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic [SEQ_W-1:0] last_commit_seq,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_incl,
  output logic [SEQ_W-1:0] whole_bound,
  output logic [SEQ_W-1:0] exe_bound
);
  localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

  always_comb begin
    whole_bound = rob_empty ? last_commit_seq : (head_seq - ONE);
    exe_bound   = exe_incl ? (exe_seq - ONE) : exe_seq;
  end
endmodule

// File: rtl/sqarb_thread.sv
module sqarb_thread
  import sqarb_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_sq,
  input  logic             xwrite_sq,
  input  logic             sqafter_set,
  input  logic             trap_wait_set,
  input  logic             exe_sq,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_incl,
  input  logic             exe_mispred,
  input  logic             exe_uncond,
  input  logic             exe_taken,
  input  logic [PC_W-1:0]  exe_pc,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic [SEQ_W-1:0] last_commit_seq,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             rob_sq_done,
  output logic             sq,
  output logic             robsq,
  output logic [SEQ_W-1:0] done_seq,
  output logic [2:0]       cause,
  output logic             taken,
  output logic             mispred,
  output logic [PC_W-1:0]  pc,
  output logic [1:0]       status,
  output logic             commit_ok
);
  tstat_e               stat_q, stat_d;
  logic [SEQ_W-1:0]     young_q, young_d;
  logic                 sq_q, robsq_q, taken_q, mispred_q;
  logic                 sq_d, robsq_d, taken_d, mispred_d;
  logic [SEQ_W-1:0]     done_q, done_d;
  cause_e               cause_q, cause_d;
  logic [PC_W-1:0]      pc_q, pc_d;
  logic                 out_en;

  logic [NUM_CAUSE-1:0] req, grant;
  cause_e               win;
  logic [SEQ_W-1:0]     whole_bound, exe_bound;
  logic                 exe_ok, accept, is_exec;

  assign exe_ok = exe_sq && (stat_q != TS_TRAP_WAIT) && (exe_seq <= young_q);
  assign req    = {exe_ok, (stat_q == TS_AFTER_WAIT), xwrite_sq, trap_sq};

  sqarb_prio u_prio (
    .req   (req),
    .grant (grant),
    .cause (win)
  );

  sqarb_bound #(.SEQ_W(SEQ_W)) u_bound (
    .rob_empty       (rob_empty),
    .head_seq        (rob_head_seq),
    .last_commit_seq (last_commit_seq),
    .exe_seq         (exe_seq),
    .exe_incl        (exe_incl),
    .whole_bound     (whole_bound),
    .exe_bound       (exe_bound)
  );

  assign accept  = |grant;
  assign is_exec = grant[3];

  // Next-state logic
  always_comb begin
    stat_d = stat_q;
    if (accept) begin
      stat_d = TS_ROB_SQ;
    end else if (stat_q == TS_ROB_SQ) begin
      if (rob_sq_done) stat_d = TS_RUN;
    end else if (stat_q == TS_RUN) begin
      if (trap_wait_set)    stat_d = TS_TRAP_WAIT;
      else if (sqafter_set) stat_d = TS_AFTER_WAIT;
    end

    young_d = young_q;
    if (accept)
      young_d = is_exec ? exe_bound : last_commit_seq;
    else if (ins_valid && (stat_q != TS_ROB_SQ) && (stat_q != TS_TRAP_WAIT))
      young_d = ins_seq;

    sq_d      = accept;
    robsq_d   = accept || ((stat_q == TS_ROB_SQ) && !rob_sq_done);
    out_en    = accept;
    done_d    = is_exec ? exe_bound : whole_bound;
    cause_d   = win;
    mispred_d = is_exec && exe_mispred;
    taken_d   = is_exec && (exe_taken || (exe_mispred && exe_uncond));
    pc_d      = is_exec ? exe_pc : cur_pc;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= TS_RUN;
      young_q   <= '0;
      sq_q      <= 1'b0;
      robsq_q   <= 1'b0;
      done_q    <= '0;
      cause_q   <= SC_NONE;
      mispred_q <= 1'b0;
      taken_q   <= 1'b0;
      pc_q      <= '0;
    end else begin
      stat_q  <= stat_d;
      young_q <= young_d;
      sq_q    <= sq_d;
      robsq_q <= robsq_d;
      if (out_en) begin
        done_q    <= done_d;
        cause_q   <= cause_d;
        mispred_q <= mispred_d;
        taken_q   <= taken_d;
        pc_q      <= pc_d;
      end
    end
  end

  assign sq        = sq_q;
  assign robsq     = robsq_q;
  assign done_seq  = done_q;
  assign cause     = cause_q;
  assign taken     = taken_q;
  assign mispred   = mispred_q;
  assign pc        = pc_q;
  assign status    = stat_q;
  assign commit_ok = (stat_q != TS_ROB_SQ);

  // R1: one winner at most, and a trap request always wins
  a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r1_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap_sq |=> (sq && cause == SC_TRAP));
  // R2: request exclusivity assumptions
  a_r2_trap_xwrite_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_sq && xwrite_sq));
  a_r2_no_xwrite_in_trap_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !(xwrite_sq && stat_q == TS_TRAP_WAIT));
  // R3: trap-wait blocks an execute squash
  a_r3_trap_wait_blocks_exe: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == TS_TRAP_WAIT && !trap_sq) |=> !sq);
  // R4: youngest follows an execute boundary
  a_r4_young_is_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sq && cause == SC_EXEC) |-> (young_q == done_seq));
  // R7: a broadcast squash comes with the squashing status
  a_r7_sq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    sq |-> (stat_q == TS_ROB_SQ && robsq));
  // R8: squashing status holds until the walk completes
  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == TS_ROB_SQ && !rob_sq_done) |=> (stat_q == TS_ROB_SQ && robsq));
endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter #(
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_THREADS-1:0]              trap_sq_i,
  input  logic [NUM_THREADS-1:0]              xwrite_sq_i,
  input  logic [NUM_THREADS-1:0]              sqafter_set_i,
  input  logic [NUM_THREADS-1:0]              trap_wait_set_i,
  input  logic [NUM_THREADS-1:0]              exe_sq_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   exe_seq_i,
  input  logic [NUM_THREADS-1:0]              exe_incl_i,
  input  logic [NUM_THREADS-1:0]              exe_mispred_i,
  input  logic [NUM_THREADS-1:0]              exe_uncond_i,
  input  logic [NUM_THREADS-1:0]              exe_taken_i,
  input  logic [NUM_THREADS-1:0][PC_W-1:0]    exe_pc_i,
  input  logic [NUM_THREADS-1:0][PC_W-1:0]    cur_pc_i,
  input  logic [NUM_THREADS-1:0]              rob_empty_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   rob_head_seq_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   last_commit_seq_i,
  input  logic [NUM_THREADS-1:0]              ins_valid_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   ins_seq_i,
  input  logic [NUM_THREADS-1:0]              rob_sq_done_i,
  output logic [NUM_THREADS-1:0]              sq_o,
  output logic [NUM_THREADS-1:0]              robsq_o,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   done_seq_o,
  output logic [NUM_THREADS-1:0][2:0]         cause_o,
  output logic [NUM_THREADS-1:0]              taken_o,
  output logic [NUM_THREADS-1:0]              mispred_o,
  output logic [NUM_THREADS-1:0][PC_W-1:0]    pc_o,
  output logic [NUM_THREADS-1:0][1:0]         status_o,
  output logic [NUM_THREADS-1:0]              commit_ok_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    sqarb_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_thr (
      .clk             (clk),
      .rst_n           (rst_n),
      .trap_sq         (trap_sq_i[t]),
      .xwrite_sq       (xwrite_sq_i[t]),
      .sqafter_set     (sqafter_set_i[t]),
      .trap_wait_set   (trap_wait_set_i[t]),
      .exe_sq          (exe_sq_i[t]),
      .exe_seq         (exe_seq_i[t]),
      .exe_incl        (exe_incl_i[t]),
      .exe_mispred     (exe_mispred_i[t]),
      .exe_uncond      (exe_uncond_i[t]),
      .exe_taken       (exe_taken_i[t]),
      .exe_pc          (exe_pc_i[t]),
      .cur_pc          (cur_pc_i[t]),
      .rob_empty       (rob_empty_i[t]),
      .rob_head_seq    (rob_head_seq_i[t]),
      .last_commit_seq (last_commit_seq_i[t]),
      .ins_valid       (ins_valid_i[t]),
      .ins_seq         (ins_seq_i[t]),
      .rob_sq_done     (rob_sq_done_i[t]),
      .sq              (sq_o[t]),
      .robsq           (robsq_o[t]),
      .done_seq        (done_seq_o[t]),
      .cause           (cause_o[t]),
      .taken           (taken_o[t]),
      .mispred         (mispred_o[t]),
      .pc              (pc_o[t]),
      .status          (status_o[t]),
      .commit_ok       (commit_ok_o[t])
    );
  end
endmodule

// File: tb/sim_squash_arbiter.sv
`timescale 1ns/1ps
module sim_squash_arbiter;
  localparam int NT = 2;
  localparam int SW = 16;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NT-1:0] trap_sq, xwrite_sq, sqafter_set, trap_wait_set, exe_sq;
  logic [NT-1:0][SW-1:0] exe_seq, rob_head_seq, last_commit_seq, ins_seq;
  logic [NT-1:0] exe_incl, exe_mispred, exe_uncond, exe_taken, rob_empty;
  logic [NT-1:0][PW-1:0] exe_pc, cur_pc;
  logic [NT-1:0] ins_valid, rob_sq_done;
  logic [NT-1:0] sq, robsq, taken, mispred, commit_ok;
  logic [NT-1:0][SW-1:0] done_seq;
  logic [NT-1:0][2:0] cause;
  logic [NT-1:0][PW-1:0] pc;
  logic [NT-1:0][1:0] status;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  squash_arbiter #(.NUM_THREADS(NT), .SEQ_W(SW), .PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .trap_sq_i(trap_sq), .xwrite_sq_i(xwrite_sq), .sqafter_set_i(sqafter_set),
    .trap_wait_set_i(trap_wait_set), .exe_sq_i(exe_sq), .exe_seq_i(exe_seq),
    .exe_incl_i(exe_incl), .exe_mispred_i(exe_mispred), .exe_uncond_i(exe_uncond),
    .exe_taken_i(exe_taken), .exe_pc_i(exe_pc), .cur_pc_i(cur_pc),
    .rob_empty_i(rob_empty), .rob_head_seq_i(rob_head_seq),
    .last_commit_seq_i(last_commit_seq), .ins_valid_i(ins_valid), .ins_seq_i(ins_seq),
    .rob_sq_done_i(rob_sq_done),
    .sq_o(sq), .robsq_o(robsq), .done_seq_o(done_seq), .cause_o(cause),
    .taken_o(taken), .mispred_o(mispred), .pc_o(pc), .status_o(status),
    .commit_ok_o(commit_ok)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulses_off();
    trap_sq = '0; xwrite_sq = '0; sqafter_set = '0; trap_wait_set = '0;
    exe_sq = '0; exe_incl = '0; exe_mispred = '0; exe_uncond = '0; exe_taken = '0;
    ins_valid = '0; rob_sq_done = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic insert(input int t, input logic [SW-1:0] s);
    ins_valid[t] = 1'b1; ins_seq[t] = s;
    step();
    pulses_off();
  endtask

  task automatic finish_squash(input int t);
    rob_sq_done[t] = 1'b1;
    step();
    pulses_off();
  endtask

  task automatic t_reset();
    chk("R8", "reset status0", 32'(status[0]), 0);
    chk("R8", "reset commit_ok", 32'(commit_ok), 32'h3);
    chk("R7", "reset sq", 32'(sq), 0);
    chk("R7", "reset robsq", 32'(robsq), 0);
  endtask

  task automatic t_exe_incl();
    insert(0, 16'd10);
    exe_sq[0] = 1; exe_seq[0] = 16'd8; exe_incl[0] = 1; exe_mispred[0] = 1;
    exe_pc[0] = 32'h100;
    step(); pulses_off();
    chk("R7", "exe sq", 32'(sq[0]), 1);
    chk("R4", "exe incl boundary", 32'(done_seq[0]), 7);
    chk("R1", "exe cause", 32'(cause[0]), 4);
    chk("R7", "status rob-sq", 32'(status[0]), 2);
    chk("R7", "pc exe", pc[0], 32'h100);
    chk("R6", "mispred", 32'(mispred[0]), 1);
    chk("R6", "taken cond", 32'(taken[0]), 0);
    chk("R8", "commit blocked", 32'(commit_ok[0]), 0);
    chk("R11", "other thread idle", 32'(sq[1]), 0);
    chk("R11", "other thread status", 32'(status[1]), 0);
    step();
    chk("R8", "still squashing", 32'(status[0]), 2);
    chk("R8", "robsq held", 32'(robsq[0]), 1);
    chk("R7", "sq one cycle", 32'(sq[0]), 0);
    finish_squash(0);
    chk("R8", "back to run", 32'(status[0]), 0);
    chk("R8", "commit ok", 32'(commit_ok[0]), 1);
    chk("R8", "robsq drop", 32'(robsq[0]), 0);
  endtask

  task automatic t_exe_reject_and_excl();
    exe_sq[0] = 1; exe_seq[0] = 16'd9;
    step(); pulses_off();
    chk("R3", "younger than youngest ignored", 32'(sq[0]), 0);
    chk("R3", "status unchanged", 32'(status[0]), 0);
    exe_sq[0] = 1; exe_seq[0] = 16'd7; exe_incl[0] = 0; exe_pc[0] = 32'h140;
    step(); pulses_off();
    chk("R4", "equal seq taken", 32'(sq[0]), 1);
    chk("R4", "no-incl boundary", 32'(done_seq[0]), 7);
    finish_squash(0);
  endtask

  task automatic t_uncond();
    insert(0, 16'd20);
    exe_sq[0] = 1; exe_seq[0] = 16'd15; exe_mispred[0] = 1; exe_uncond[0] = 1;
    exe_taken[0] = 0;
    step(); pulses_off();
    chk("R6", "uncond forces taken", 32'(taken[0]), 1);
    chk("R4", "uncond boundary", 32'(done_seq[0]), 15);
    finish_squash(0);
  endtask

  task automatic t_trap_whole();
    insert(0, 16'd30);
    rob_empty[0] = 1; last_commit_seq[0] = 16'd5; cur_pc[0] = 32'h200;
    trap_sq[0] = 1;
    step(); pulses_off();
    chk("R5", "empty boundary", 32'(done_seq[0]), 5);
    chk("R1", "trap cause", 32'(cause[0]), 1);
    chk("R7", "pc commit", pc[0], 32'h200);
    chk("R6", "whole mispred", 32'(mispred[0]), 0);
    // R9: insert during squash must not raise the youngest number
    ins_valid[0] = 1; ins_seq[0] = 16'd50;
    step(); pulses_off();
    finish_squash(0);
    exe_sq[0] = 1; exe_seq[0] = 16'd6;
    step(); pulses_off();
    chk("R5", "youngest reset to last commit", 32'(sq[0]), 0);
    exe_sq[0] = 1; exe_seq[0] = 16'd40;
    step(); pulses_off();
    chk("R9", "insert in squash ignored", 32'(sq[0]), 0);
  endtask

  task automatic t_priority();
    insert(0, 16'd60);
    rob_empty[0] = 0; rob_head_seq[0] = 16'd12;
    trap_sq[0] = 1; exe_sq[0] = 1; exe_seq[0] = 16'd55; exe_pc[0] = 32'h300;
    step(); pulses_off();
    chk("R1", "trap beats exe", 32'(cause[0]), 1);
    chk("R5", "head boundary", 32'(done_seq[0]), 11);
    finish_squash(0);
    sqafter_set[0] = 1;
    step(); pulses_off();
    chk("R10", "after-wait status", 32'(status[0]), 3);
    chk("R10", "no squash yet", 32'(sq[0]), 0);
    xwrite_sq[0] = 1;
    step(); pulses_off();
    chk("R1", "xwrite beats after", 32'(cause[0]), 2);
    finish_squash(0);
    sqafter_set[0] = 1;
    step(); pulses_off();
    step();
    chk("R10", "after squash fires", 32'(sq[0]), 1);
    chk("R1", "after cause", 32'(cause[0]), 3);
    finish_squash(0);
  endtask

  task automatic t_trap_wait();
    insert(0, 16'd70);
    trap_wait_set[0] = 1;
    step(); pulses_off();
    chk("R10", "trap-wait status", 32'(status[0]), 1);
    exe_sq[0] = 1; exe_seq[0] = 16'd65;
    step(); pulses_off();
    chk("R3", "exe blocked in trap-wait", 32'(sq[0]), 0);
    chk("R3", "still trap-wait", 32'(status[0]), 1);
    trap_sq[0] = 1;
    step(); pulses_off();
    chk("R10", "trap leaves trap-wait", 32'(status[0]), 2);
    finish_squash(0);
  endtask

  task automatic t_thread1();
    insert(1, 16'd90);
    exe_sq[1] = 1; exe_seq[1] = 16'd88; exe_pc[1] = 32'h500;
    step(); pulses_off();
    chk("R11", "thread1 squash", 32'(sq[1]), 1);
    chk("R11", "thread1 boundary", 32'(done_seq[1]), 88);
    chk("R11", "thread0 untouched", 32'(status[0]), 0);
    chk("R11", "thread0 commit ok", 32'(commit_ok[0]), 1);
    finish_squash(1);
  endtask

  initial begin
    pulses_off();
    exe_seq = '0; rob_head_seq = '0; last_commit_seq = '0; ins_seq = '0;
    exe_pc = '0; cur_pc = '0; rob_empty = '1;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_exe_incl();
    t_exe_reject_and_excl();
    t_uncond();
    t_trap_whole();
    t_priority();
    t_trap_wait();
    t_thread1();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule